// File: doc/BRIEF.md
# Flash Command Interface and Bus Controller

This block is the host-facing front end of a behavioural flash model. It watches the chip-enable, output-enable and write-enable strobes (already synchronized to the model clock) and a bus reset. It captures the address when chip enable falls and the write data when write enable rises. Every write cycle is treated as a command byte. Commands choose what a read returns: the memory array, the identifier codes, the query table or the status byte. Commands that alter the memory must arrive as a setup cycle followed by a confirm cycle. Once confirmed, they are passed to a program/erase sequencer as a single-cycle request.

The read path is a gated multiplexer. Its output enable stands in for a tri-state driver. Whenever the sequencer reports busy, reads return status, whatever read mode is selected. A bus reset returns the block to array reads and clears the error flags. It also stops the block from driving the bus.

Top module: `flashCmdIf`

## Requirements
- R1: While the bus reset is low, and after it is released, the read mode is array, `rdataOe` is 0, `seqReq` is 0 and both error flags are clear.
- R2: `memAddr` takes the value of `addr` in the cycle chip enable falls and holds it until the next fall. Changing `addr` while chip enable stays low does not change what is read.
- R3: The data word forwarded on `seqData` is the `wdata` present when write enable rose for the confirm/data cycle.
- R4: `rdataOe` is 1 only while `ceN`=0, `oeN`=0, `weN`=1 and `rstN`=1. Otherwise `rdataOe` is 0 and `rdata` is 0.
- R5: The low byte of a write selects the read mode. 0xFF selects array (`arrayData`). 0x90 selects identifier (`memAddr[0]`=0 gives MFR_ID, 1 gives DEV_ID). 0x98 selects query (`queryData`). 0x70 selects status.
- R6: 0x40 followed by any word issues one `seqReq` pulse with `seqOp`=1 (program) and sets the read mode to status.
- R7: 0x20 then 0xD0 issues `seqOp`=2 (erase). 0x60 then 0x01 issues `seqOp`=3 (lock). 0x60 then 0xD0 issues `seqOp`=4 (unlock). Each sets the read mode to status.
- R8: A confirm byte that does not match its setup issues no request. It sets both error flags (status bits 5 and 4) and sets the read mode to status.
- R9: 0x50 clears both error flags and leaves the read mode unchanged.
- R10: While `seqBusy`=1, reads return status and every command except 0xB0 is ignored. A read-array command is needed after busy falls to return to array reads.
- R11: 0xB0 while busy issues `seqOp`=5 (suspend). 0xD0 as a first cycle while not busy issues `seqOp`=6 (resume).
- R12: The status byte occupies `rdata[7:0]`, with bit 7 = not busy, bit 5 = erase error, bit 4 = program error and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rstN | input | 1 | Bus reset, active low, asynchronous |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| arrayData | input | DATA_W | Array word at `memAddr` |
| queryData | input | DATA_W | Query table word at `memAddr` |
| seqBusy | input | 1 | Sequencer is running an operation |
| rdata | output | DATA_W | Read data, 0 when not driven |
| rdataOe | output | 1 | Bus driver enable |
| memAddr | output | ADDR_W | Latched address for array, query and sequencer |
| seqReq | output | 1 | One-cycle request to the sequencer |
| seqOp | output | 3 | Requested operation code |
| seqData | output | DATA_W | Latched write data for the request |

## Verification
Every read mode is written and read back at several addresses. This tells the four multiplexer sources apart, and the two identifier words apart by address bit 0. Each two-cycle sequence is tried with its valid confirm bytes and with a wrong one, so that a request and an error flag cannot be confused. The busy line is raised with array mode selected, which separates the busy override from the stored mode. Commands written during busy show that they were dropped. Strobe combinations with one enable missing, and an address changed while chip enable stays low, exercise the gating and the capture point.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } readMode_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_LOCK    = 3'd3,
    OP_UNLOCK  = 3'd4,
    OP_SUSPEND = 3'd5,
    OP_RESUME  = 3'd6
  } seqOp_e;

  typedef struct packed {
    logic latchAddr;
    logic latchData;
    logic setErr;
    logic clrErr;
  } pathStrobe_t;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_WORD    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_LOCKSET = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCKBIT = 8'h01;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

endpackage

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import flashCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic [7:0]  cmdByte,
  input  logic        seqBusy,
  output pathStrobe_t strobe,
  output readMode_e   readMode,
  output logic        seqReq,
  output logic [2:0]  seqOp
);

  typedef enum logic [1:0] {ST_IDLE, ST_WORD, ST_ERASE, ST_LOCK} cmdState_e;

  cmdState_e state, nState;
  readMode_e nMode;
  seqOp_e    nOp;
  logic      nReq;
  logic      prevCe, prevWe;
  logic      ceFall, weRise;
  logic      setErr, clrErr;

  // strobe edges seen against last cycle's sample
  assign ceFall = prevCe & ~ceN;
  assign weRise = ~prevWe & weN & ~ceN;

  always_comb begin
    nState = state;
    nMode  = readMode;
    nReq   = 1'b0;
    nOp    = OP_NONE;
    setErr = 1'b0;
    clrErr = 1'b0;
    if (weRise) begin
      case (state)
        ST_IDLE: begin
          if (seqBusy) begin
            if (cmdByte == CMD_SUSPEND) begin
              nReq = 1'b1;
              nOp  = OP_SUSPEND;
            end
          end else begin
            case (cmdByte)
              CMD_ARRAY:   nMode = MODE_ARRAY;
              CMD_STATUS:  nMode = MODE_STATUS;
              CMD_IDENT:   nMode = MODE_IDENT;
              CMD_QUERY:   nMode = MODE_QUERY;
              CMD_CLEAR:   clrErr = 1'b1;
              CMD_WORD:    nState = ST_WORD;
              CMD_ERASE:   nState = ST_ERASE;
              CMD_LOCKSET: nState = ST_LOCK;
              CMD_CONFIRM: begin
                nReq = 1'b1;
                nOp  = OP_RESUME;
              end
              default: ;
            endcase
          end
        end
        ST_WORD: begin
          nReq   = 1'b1;
          nOp    = OP_PROG;
          nMode  = MODE_STATUS;
          nState = ST_IDLE;
        end
        ST_ERASE: begin
          nMode  = MODE_STATUS;
          nState = ST_IDLE;
          if (cmdByte == CMD_CONFIRM) begin
            nReq = 1'b1;
            nOp  = OP_ERASE;
          end else begin
            setErr = 1'b1;
          end
        end
        ST_LOCK: begin
          nMode  = MODE_STATUS;
          nState = ST_IDLE;
          if (cmdByte == CMD_LOCKBIT) begin
            nReq = 1'b1;
            nOp  = OP_LOCK;
          end else if (cmdByte == CMD_CONFIRM) begin
            nReq = 1'b1;
            nOp  = OP_UNLOCK;
          end else begin
            setErr = 1'b1;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latchAddr = ceFall;
    strobe.latchData = weRise;
    strobe.setErr    = setErr;
    strobe.clrErr    = clrErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCe   <= 1'b1;
      prevWe   <= 1'b1;
      state    <= ST_IDLE;
      readMode <= MODE_ARRAY;
      seqReq   <= 1'b0;
      seqOp    <= OP_NONE;
    end else begin
      prevCe   <= ceN;
      prevWe   <= weN;
      state    <= nState;
      readMode <= nMode;
      seqReq   <= nReq;
      seqOp    <= nOp;
    end
  end

  // R6
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqReq |=> !seqReq);

  // R7
  req_mode_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && seqOp != OP_SUSPEND && seqOp != OP_RESUME) |-> readMode == MODE_STATUS);

  // R8
  bad_confirm_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |=> (readMode == MODE_STATUS && !seqReq));

endmodule

// File: rtl/busPath.sv
module busPath
  import flashCmdPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 'h0042,
  parameter logic [DATA_W-1:0] DEV_ID = 'h88A1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  readMode_e         readMode,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              seqBusy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] queryData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] seqData,
  output logic [DATA_W-1:0] rdata,
  output logic              rdataOe
);

  localparam int PAD_W = DATA_W - 8;

  logic [1:0]        errBits;   // [1] erase error, [0] program error
  logic [7:0]        statusByte;
  readMode_e         effMode;
  logic [DATA_W-1:0] selData;
  logic              drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      seqData <= '0;
      errBits <= 2'b00;
    end else begin
      if (strobe.latchAddr) memAddr <= addr;
      if (strobe.latchData) seqData <= wdata;
      if (strobe.setErr)      errBits <= 2'b11;
      else if (strobe.clrErr) errBits <= 2'b00;
    end
  end

  assign statusByte = {~seqBusy, 1'b0, errBits[1], errBits[0], 4'b0000};
  assign effMode    = seqBusy ? MODE_STATUS : readMode;

  always_comb begin
    case (effMode)
      MODE_ARRAY:  selData = arrayData;
      MODE_IDENT:  selData = memAddr[0] ? DEV_ID : MFR_ID;
      MODE_QUERY:  selData = queryData;
      default:     selData = {{PAD_W{1'b0}}, statusByte};
    endcase
  end

  assign drive   = rstN & ~ceN & ~oeN & weN;
  assign rdataOe = drive;
  assign rdata   = drive ? selData : '0;

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |=> errBits == 2'b11);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrErr && !strobe.setErr) |=> errBits == 2'b00);

  // R10
  busy_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdataOe && seqBusy) |-> rdata[7] == 1'b0);

endmodule

// File: rtl/flashCmdIf.sv
module flashCmdIf
  import flashCmdPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 'h0042,
  parameter logic [DATA_W-1:0] DEV_ID = 'h88A1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] queryData,
  input  logic              seqBusy,
  output logic [DATA_W-1:0] rdata,
  output logic              rdataOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              seqReq,
  output logic [2:0]        seqOp,
  output logic [DATA_W-1:0] seqData
);

  pathStrobe_t strobe;
  readMode_e   readMode;

  cmdCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .cmdByte  (wdata[7:0]),
    .seqBusy  (seqBusy),
    .strobe   (strobe),
    .readMode (readMode),
    .seqReq   (seqReq),
    .seqOp    (seqOp)
  );

  busPath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .readMode  (readMode),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .seqBusy   (seqBusy),
    .addr      (addr),
    .wdata     (wdata),
    .arrayData (arrayData),
    .queryData (queryData),
    .memAddr   (memAddr),
    .seqData   (seqData),
    .rdata     (rdata),
    .rdataOe   (rdataOe)
  );

endmodule

// File: tb/flashCmdIf_bench.sv
`timescale 1ns/1ps
module flashCmdIf_bench;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam logic [15:0] MFR = 16'h0042;
  localparam logic [15:0] DEV = 16'h88A1;

  logic          clk = 1'b0;
  logic          rstN, ceN, oeN, weN, seqBusy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, arrayData, queryData, rdata, seqData;
  logic          rdataOe, seqReq;
  logic [AW-1:0] memAddr;
  logic [2:0]    seqOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } req_t;
  req_t  expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  assign arrayData = memAddr[15:0] ^ 16'h5A5A;
  assign queryData = {4'hC, memAddr[11:0]};

  flashCmdIf u_flashCmdIf (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .wdata(wdata), .arrayData(arrayData), .queryData(queryData),
    .seqBusy(seqBusy), .rdata(rdata), .rdataOe(rdataOe), .memAddr(memAddr),
    .seqReq(seqReq), .seqOp(seqOp), .seqData(seqData)
  );

  function automatic logic [15:0] arr(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectReq(input string tag, input logic [2:0] op,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    expQ.push_back('{op: op, a: a, d: d});
    tagQ.push_back(tag);
  endtask

  // monitor: pops the scoreboard on every sequencer request
  always @(negedge clk) begin
    if (rstN === 1'b1 && seqReq === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL unexpected request actual op %0d expected none (R8/R10)", seqOp);
      end else begin
        req_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " op"},   {29'd0, seqOp}, {29'd0, e.op});
        chk({t, " addr"}, {10'd0, memAddr}, {10'd0, e.a});
        chk({t, " data"}, {16'd0, seqData}, {16'd0, e.d});
      end
    end
  end

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; addr = a; wdata = d;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic busRead(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; addr = a;
    repeat (2) @(negedge clk);
    chk({tag, " oe"}, {31'd0, rdataOe}, 32'd1);
    chk({tag, " data"}, {16'd0, rdata}, {16'd0, exp});
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    seqBusy = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {31'd0, rdataOe}, 32'd0);
    chk("R1 reset req", {31'd0, seqReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    busRead("R1 array after reset", 22'h5, arr(22'h5));
    busWrite(22'h0, 16'h0070);
    busRead("R1 errors clear", 22'h0, 16'h0080);
    busWrite(22'h0, 16'h00FF);

    // R4 gating
    ceN = 1'b1; oeN = 1'b0; repeat (2) @(negedge clk);
    chk("R4 ce high oe", {31'd0, rdataOe}, 32'd0);
    chk("R4 ce high data", {16'd0, rdata}, 32'd0);
    ceN = 1'b0; oeN = 1'b1; repeat (2) @(negedge clk);
    chk("R4 oe high", {31'd0, rdataOe}, 32'd0);
    oeN = 1'b0; weN = 1'b0; repeat (2) @(negedge clk);
    chk("R4 we low", {31'd0, rdataOe}, 32'd0);
    oeN = 1'b1; ceN = 1'b1; @(negedge clk);
    weN = 1'b1; repeat (2) @(negedge clk);

    // R2 address held from chip-enable fall
    ceN = 1'b0; oeN = 1'b0; addr = 22'h1234;
    repeat (2) @(negedge clk);
    addr = 22'h0777;
    repeat (2) @(negedge clk);
    chk("R2 address hold", {16'd0, rdata}, {16'd0, arr(22'h1234)});
    ceN = 1'b1; oeN = 1'b1; @(negedge clk);

    // R5 read modes
    busWrite(22'h0, 16'h0090);
    busRead("R5 ident mfr", 22'h0, MFR);
    busRead("R5 ident dev", 22'h1, DEV);
    busWrite(22'h0, 16'h0098);
    busRead("R5 query", 22'h3, {4'hC, 12'h003});
    busWrite(22'h0, 16'h0070);
    busRead("R12 status idle", 22'h0, 16'h0080);
    busWrite(22'h0, 16'h00FF);
    busRead("R5 array", 22'h7, arr(22'h7));

    // R6 / R3 word write
    expectReq("R6 R3 program", 3'd1, 22'h12, 16'h1234);
    busWrite(22'h12, 16'h0040);
    busWrite(22'h12, 16'h1234);
    busRead("R6 mode status", 22'h12, 16'h0080);

    // R7 erase, lock, unlock
    expectReq("R7 erase", 3'd2, 22'h300, 16'h00D0);
    busWrite(22'h300, 16'h0020);
    busWrite(22'h300, 16'h00D0);
    expectReq("R7 lock", 3'd3, 22'h400, 16'h0001);
    busWrite(22'h400, 16'h0060);
    busWrite(22'h400, 16'h0001);
    expectReq("R7 unlock", 3'd4, 22'h401, 16'h00D0);
    busWrite(22'h401, 16'h0060);
    busWrite(22'h401, 16'h00D0);
    busRead("R7 mode status", 22'h401, 16'h0080);

    // R8 bad confirm
    busWrite(22'h0, 16'h00FF);
    busWrite(22'h500, 16'h0020);
    busWrite(22'h500, 16'h0033);
    busRead("R8 erase bad confirm", 22'h500, 16'h00B0);
    busWrite(22'h0, 16'h00FF);
    busWrite(22'h501, 16'h0060);
    busWrite(22'h501, 16'h0077);
    busRead("R8 lock bad confirm", 22'h501, 16'h00B0);
    chk("R8 no request queued", expQ.size(), 32'd0);

    // R9 clear status
    busWrite(22'h0, 16'h0050);
    busRead("R9 cleared", 22'h0, 16'h0080);

    // R10 busy override and ignored commands
    busWrite(22'h0, 16'h00FF);
    busRead("R10 array before busy", 22'h9, arr(22'h9));
    seqBusy = 1'b1;
    busRead("R10 busy shows status", 22'h9, 16'h0000);
    busWrite(22'h0, 16'h0090);
    seqBusy = 1'b0;
    busRead("R10 command ignored while busy", 22'h9, arr(22'h9));

    expectReq("R10 program", 3'd1, 22'h20, 16'hBEEF);
    busWrite(22'h20, 16'h0040);
    busWrite(22'h20, 16'hBEEF);
    seqBusy = 1'b1;
    busRead("R10 status during op", 22'h20, 16'h0000);
    busWrite(22'h0, 16'h00FF);
    seqBusy = 1'b0;
    busRead("R10 status after done", 22'h20, 16'h0080);
    busWrite(22'h0, 16'h00FF);
    busRead("R10 array after release", 22'h20, arr(22'h20));

    // R11 suspend and resume
    seqBusy = 1'b1;
    expectReq("R11 suspend", 3'd5, 22'h30, 16'h00B0);
    busWrite(22'h30, 16'h00B0);
    seqBusy = 1'b0;
    expectReq("R11 resume", 3'd6, 22'h31, 16'h00D0);
    busWrite(22'h31, 16'h00D0);

    // R1 reset mid-mode
    busWrite(22'h0, 16'h0090);
    busWrite(22'h600, 16'h0020);
    busWrite(22'h600, 16'h0011);
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 no drive in reset", {31'd0, rdataOe}, 32'd0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead("R1 array after reset exit", 22'h2, arr(22'h2));
    busWrite(22'h0, 16'h0070);
    busRead("R1 errors cleared by reset", 22'h0, 16'h0080);

    repeat (4) @(negedge clk);
    chk("R6 all requests seen", expQ.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule